// File: doc/BRIEF.md
# Motor Drive Power-Up and Shutdown Sequencer

This block is the supervisory state machine that takes a motor drive from cold power-up to a running state and back down again. On leaving reset it keeps the slave control processor in reset and leaves both contactors open. An operator start releases the processor and waits for the parameter exchange to finish. The sequencer then checks the health signal and closes the charging contactor for a fixed two-second window. At the end of that window it compares the DC bus sample against a programmable rated value. If the bus is high enough, it opens the charging contactor and closes the main contactor, with one dead cycle between them. Finally it raises the run command to the processor.

An operator stop or a protection trip unwinds the drive in a fixed order. The run command drops first, then the processor reset is asserted, and only then does the main contactor open. A stop returns the block to idle. A trip, a failed health check or a low bus ends in a latched fault state that carries a cause code. Only the operator fault-clear input leaves that state. All outputs are decoded from the registered state, so each one changes one clock after the input that caused it.

Top module: `drvseq_top`

## Requirements
- R1: After reset, slave_rst_n is 0, both contactor commands and run_cmd are 0, fault_flag is 0 and fault_code is 0. The block stays that way until start_req is seen.
- R2: A start_req in idle drives slave_rst_n to 1 on the next cycle. Both contactors stay open until params_done is seen.
- R3: After params_done, healthy is checked once. If it is 0, the block ends in the fault state with fault_code 1, and the charging contactor never closes.
- R4: If healthy is 1, chg_close stays high for exactly CLK_HZ/1000*DELAY_MS consecutive cycles.
- R5: At the end of that window the bus passes when bus_sample*5 >= bus_rated*4. A pass leads to run_cmd=1. A fail ends in the fault state with fault_code 2.
- R6: On a pass, chg_close falls, the next cycle has both contactors open, the cycle after that closes main_close with run_cmd still 0, and run_cmd rises one cycle later.
- R7: chg_close and main_close are never 1 in the same cycle.
- R8: A stop_req while running clears run_cmd first, with slave_rst_n=1 and main_close=1. The next cycle sets slave_rst_n to 0 with main still closed. The cycle after that opens main_close and returns to idle with fault_flag 0.
- R9: A trip in any state from parameter exchange to running follows the same three-step order as R8 and ends in the fault state with fault_code 3. Trip wins over a simultaneous stop.
- R10: The fault state holds, with slave_rst_n 0 and a start_req having no effect, until fault_clr. fault_clr returns the block to idle with fault_flag 0 and fault_code 0.
- R11: start_req outside idle has no effect. In the running state run_cmd and main_close stay 1.
- R12: stop_req in idle has no effect. slave_rst_n stays 0 and the contactors stay open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Operator start command |
| stop_req | input | 1 | Operator stop command |
| fault_clr | input | 1 | Operator fault acknowledge |
| params_done | input | 1 | Parameter exchange with the processor finished |
| healthy | input | 1 | Power stage health status |
| trip | input | 1 | Protection trip |
| bus_sample | input | BUS_W | DC bus voltage sample |
| bus_rated | input | BUS_W | Rated DC bus voltage |
| slave_rst_n | output | 1 | Active-low reset to the control processor |
| chg_close | output | 1 | Close command for the charging contactor |
| main_close | output | 1 | Close command for the main contactor |
| run_cmd | output | 1 | Run command to the processor |
| fault_flag | output | 1 | Latched fault state |
| fault_code | output | 2 | Fault cause: 0 none, 1 unhealthy, 2 bus low, 3 trip |

## Verification
The hardest case to reach is the bus verdict at the last cycle of the precharge window, because it needs thousands of cycles of a correctly sequenced start first. The bench scales CLK_HZ down so the window is 2000 cycles. It then walks a table of bus/rated pairs that sit exactly on, and one count below, the 80 % boundary, timing each window and following every outcome to run or to fault. Trips are driven together with stops, both while running and during parameter exchange, to confirm that trip wins and that the unwind order holds.

// File: rtl/drvseq_pkg.sv
package drvseq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PARAM,
      ST_HEALTH,
      ST_PRECHG,
      ST_SWAP,
      ST_MAIN,
      ST_RUN,
      ST_SD_RUN,
      ST_SD_RST,
      ST_FAULT
   } seq_state_e;

   localparam logic [1:0] FC_NONE      = 2'd0;
   localparam logic [1:0] FC_UNHEALTHY = 2'd1;
   localparam logic [1:0] FC_BUSLOW    = 2'd2;
   localparam logic [1:0] FC_TRIP      = 2'd3;

endpackage

// File: rtl/drvseq_hold_timer.sv
module drvseq_hold_timer #(
   parameter int unsigned LIMIT = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("drvseq_hold_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign done = run && (cnt_q == LAST);

endmodule

// File: rtl/drvseq_bus_check.sv
module drvseq_bus_check #(
   parameter int unsigned BUS_W   = 12,
   parameter int unsigned CONFIRM = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BUS_W-1:0] bus_sample,
   input  logic [BUS_W-1:0] bus_rated,
   output logic             bus_ok
);
   localparam int unsigned XW = BUS_W + 3;

   if (CONFIRM != 1 && CONFIRM != 2) begin : g_bad_confirm
      $error("drvseq_bus_check: CONFIRM must be 1 or 2");
   end

   logic [XW-1:0] lhs, rhs;
   logic          pass_now;
   logic          pass_q;

   // bus*5 versus rated*4, done with shifts and one adder
   assign lhs      = ({3'b000, bus_sample} << 2) + {3'b000, bus_sample};
   assign rhs      = {3'b000, bus_rated} << 2;
   assign pass_now = (lhs >= rhs);

   always_ff @(posedge clk) begin
      if (!rst_n) pass_q <= 1'b0;
      else        pass_q <= pass_now;
   end

   if (CONFIRM == 2) begin : g_two_sample
      logic pass_qq;
      always_ff @(posedge clk) begin
         if (!rst_n) pass_qq <= 1'b0;
         else        pass_qq <= pass_q;
      end
      assign bus_ok = pass_q && pass_qq;
   end else begin : g_one_sample
      assign bus_ok = pass_q;
   end

endmodule

// File: rtl/drvseq_ctrl.sv
module drvseq_ctrl
   import drvseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_req,
   input  logic       stop_req,
   input  logic       fault_clr,
   input  logic       params_done,
   input  logic       healthy,
   input  logic       trip,
   input  logic       tmr_done,
   input  logic       bus_ok,
   output logic       tmr_run,
   output logic       slave_rst_n,
   output logic       chg_close,
   output logic       main_close,
   output logic       run_cmd,
   output logic       fault_flag,
   output logic [1:0] fault_code
);
   seq_state_e st, nxt;
   logic       to_fault_q, hold_main_q;
   logic [1:0] code_q;
   logic       enter_sd, sd_fault, powered;
   logic [1:0] sd_code;

   assign powered = (st == ST_PARAM) || (st == ST_HEALTH) || (st == ST_PRECHG) ||
                    (st == ST_SWAP)  || (st == ST_MAIN)   || (st == ST_RUN);

   always_comb begin
      nxt      = st;
      enter_sd = 1'b0;
      sd_fault = 1'b0;
      sd_code  = FC_NONE;
      if (powered && (trip || stop_req)) begin
         nxt      = ST_SD_RUN;
         enter_sd = 1'b1;
         sd_fault = trip;
         sd_code  = trip ? FC_TRIP : FC_NONE;
      end else begin
         unique case (st)
            ST_IDLE:   if (start_req) nxt = ST_PARAM;
            ST_PARAM:  if (params_done) nxt = ST_HEALTH;
            ST_HEALTH: begin
               if (healthy) nxt = ST_PRECHG;
               else begin
                  nxt      = ST_SD_RUN;
                  enter_sd = 1'b1;
                  sd_fault = 1'b1;
                  sd_code  = FC_UNHEALTHY;
               end
            end
            ST_PRECHG: begin
               if (tmr_done) begin
                  if (bus_ok) nxt = ST_SWAP;
                  else begin
                     nxt      = ST_SD_RUN;
                     enter_sd = 1'b1;
                     sd_fault = 1'b1;
                     sd_code  = FC_BUSLOW;
                  end
               end
            end
            ST_SWAP:   nxt = ST_MAIN;
            ST_MAIN:   nxt = ST_RUN;
            ST_RUN:    nxt = ST_RUN;
            ST_SD_RUN: nxt = ST_SD_RST;
            ST_SD_RST: nxt = to_fault_q ? ST_FAULT : ST_IDLE;
            ST_FAULT:  if (fault_clr) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         to_fault_q  <= 1'b0;
         hold_main_q <= 1'b0;
         code_q      <= FC_NONE;
      end else begin
         st <= nxt;
         if (enter_sd) begin
            to_fault_q  <= sd_fault;
            code_q      <= sd_code;
            hold_main_q <= main_close;
         end else if (st == ST_FAULT && fault_clr) begin
            code_q <= FC_NONE;
         end
      end
   end

   assign tmr_run     = (st == ST_PRECHG);
   assign slave_rst_n = !((st == ST_IDLE) || (st == ST_SD_RST) || (st == ST_FAULT));
   assign chg_close   = (st == ST_PRECHG);
   assign main_close  = (st == ST_MAIN) || (st == ST_RUN) ||
                        (((st == ST_SD_RUN) || (st == ST_SD_RST)) && hold_main_q);
   assign run_cmd     = (st == ST_RUN);
   assign fault_flag  = (st == ST_FAULT);
   assign fault_code  = fault_flag ? code_q : FC_NONE;

   // R7: contactors mutually exclusive
   p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(chg_close && main_close));

   // R6: main closes only after a cycle with the charging contactor open
   p_dead_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_close) |-> !$past(chg_close));

   // R6: run only with main closed and processor released
   p_run_needs_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run_cmd |-> (main_close && slave_rst_n));

   // R8: run drops while processor still released and main still closed
   p_run_drops_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_cmd) |-> (slave_rst_n && main_close));

   // R8: main opens only after the processor reset was already asserted
   p_main_opens_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(main_close) |-> (!slave_rst_n && !run_cmd && !$past(slave_rst_n)));

   // R11: start is ignored while running
   p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && start_req && !stop_req && !trip) |=> (st == ST_RUN));

   // R10: fault holds until acknowledged
   p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FAULT && !fault_clr) |=> (st == ST_FAULT && fault_code != FC_NONE));

endmodule

// File: rtl/drvseq_top.sv
module drvseq_top #(
   parameter int unsigned BUS_W    = 12,
   parameter int unsigned CLK_HZ   = 125_000_000,
   parameter int unsigned DELAY_MS = 2000,
   parameter int unsigned CONFIRM  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic             fault_clr,
   input  logic             params_done,
   input  logic             healthy,
   input  logic             trip,
   input  logic [BUS_W-1:0] bus_sample,
   input  logic [BUS_W-1:0] bus_rated,
   output logic             slave_rst_n,
   output logic             chg_close,
   output logic             main_close,
   output logic             run_cmd,
   output logic             fault_flag,
   output logic [1:0]       fault_code
);
   localparam longint unsigned HOLD_CYCLES = (longint'(CLK_HZ) / 1000) * longint'(DELAY_MS);

   if (BUS_W < 4 || BUS_W > 28) begin : g_bad_bus_w
      $error("drvseq_top: BUS_W out of range");
   end
   if (CLK_HZ < 1000) begin : g_bad_clk
      $error("drvseq_top: CLK_HZ must be at least 1000");
   end
   if (DELAY_MS < 1 || HOLD_CYCLES > 64'hFFFF_FFFF) begin : g_bad_delay
      $error("drvseq_top: DELAY_MS out of range");
   end

   logic tmr_run, tmr_done, bus_ok;

   drvseq_hold_timer #(
      .LIMIT(int'(HOLD_CYCLES))
   ) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (tmr_run),
      .done (tmr_done)
   );

   drvseq_bus_check #(
      .BUS_W  (BUS_W),
      .CONFIRM(CONFIRM)
   ) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sample(bus_sample),
      .bus_rated (bus_rated),
      .bus_ok    (bus_ok)
   );

   drvseq_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (start_req),
      .stop_req   (stop_req),
      .fault_clr  (fault_clr),
      .params_done(params_done),
      .healthy    (healthy),
      .trip       (trip),
      .tmr_done   (tmr_done),
      .bus_ok     (bus_ok),
      .tmr_run    (tmr_run),
      .slave_rst_n(slave_rst_n),
      .chg_close  (chg_close),
      .main_close (main_close),
      .run_cmd    (run_cmd),
      .fault_flag (fault_flag),
      .fault_code (fault_code)
   );

endmodule

// File: tb/drvseq_top_test.sv
module drvseq_top_test;
   localparam int BW     = 12;
   localparam int CLKHZ  = 1000;   // scaled so the 2 s window is 2000 cycles
   localparam int DLYMS  = 2000;
   localparam int WINDOW = CLKHZ / 1000 * DLYMS;
   localparam int NVEC   = 6;
   // {bus[11:0], rated[11:0], expected pass}
   localparam logic [24:0] VEC [NVEC] = '{
      {12'd800,  12'd1000, 1'b1},
      {12'd799,  12'd1000, 1'b0},
      {12'd1000, 12'd1000, 1'b1},
      {12'd0,    12'd1000, 1'b0},
      {12'd4,    12'd5,    1'b1},
      {12'd3,    12'd5,    1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_req = 0, stop_req = 0, fault_clr = 0, params_done = 0, healthy = 1, trip = 0;
   logic [BW-1:0] bus_sample = '0, bus_rated = '0;
   logic slave_rst_n, chg_close, main_close, run_cmd, fault_flag;
   logic [1:0] fault_code;

   int n_chk = 0, n_bad = 0;
   bit overlap_seen = 0, chg_seen = 0, main_seen = 0;

   always #4 clk = ~clk;

   drvseq_top #(.BUS_W(BW), .CLK_HZ(CLKHZ), .DELAY_MS(DLYMS), .CONFIRM(1)) uut (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
      .fault_clr(fault_clr), .params_done(params_done), .healthy(healthy), .trip(trip),
      .bus_sample(bus_sample), .bus_rated(bus_rated), .slave_rst_n(slave_rst_n),
      .chg_close(chg_close), .main_close(main_close), .run_cmd(run_cmd),
      .fault_flag(fault_flag), .fault_code(fault_code));

   always @(negedge clk) begin
      if (chg_close && main_close) overlap_seen = 1;
      if (chg_close) chg_seen = 1;
      if (main_close) main_seen = 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic nclk(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic pulse_start();
      start_req = 1; nclk(1); start_req = 0;
   endtask

   task automatic pass_params();
      params_done = 1; nclk(1); params_done = 0;
   endtask

   // returns number of cycles chg_close was high; ends on first cycle after it falls
   task automatic run_window(output int cnt);
      cnt = 0;
      while (!chg_close && cnt < 10) begin nclk(1); cnt++; end
      cnt = 0;
      while (chg_close) begin cnt++; nclk(1); end
   endtask

   task automatic clear_fault();
      fault_clr = 1; nclk(1); fault_clr = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      int cnt;
      nclk(3);
      rst_n = 1;
      nclk(1);
      // R1: reset state
      chk(slave_rst_n == 0 && chg_close == 0 && main_close == 0 && run_cmd == 0,
          "R1 reset outputs", {slave_rst_n, chg_close, main_close, run_cmd}, 0);
      chk(fault_flag == 0 && fault_code == 0, "R1 reset fault", {fault_flag, fault_code}, 0);
      nclk(5);
      chk(slave_rst_n == 0, "R1 held idle", slave_rst_n, 0);

      // R12: stop in idle ignored
      stop_req = 1; nclk(1); stop_req = 0; nclk(1);
      chk(slave_rst_n == 0 && !chg_close && !main_close && !fault_flag,
          "R12 stop in idle", {slave_rst_n, chg_close, main_close, fault_flag}, 0);

      // table of bus threshold vectors (R2 R4 R5 R6 R8)
      for (int i = 0; i < NVEC; i++) begin
         bus_sample = VEC[i][24:13];
         bus_rated  = VEC[i][12:1];
         healthy    = 1;
         pulse_start();
         chk(slave_rst_n == 1 && !chg_close && !main_close, "R2 release",
             {slave_rst_n, chg_close, main_close}, 4);
         nclk(2);
         chk(!chg_close && !main_close, "R2 wait params", {chg_close, main_close}, 0);
         pass_params();
         run_window(cnt);
         chk(cnt == WINDOW, "R4 window length", cnt, WINDOW);
         if (VEC[i][0]) begin
            chk(!chg_close && !main_close, "R6 dead cycle", {chg_close, main_close}, 0);
            nclk(1);
            chk(main_close && !run_cmd, "R6 main before run", {main_close, run_cmd}, 2);
            nclk(1);
            chk(run_cmd && main_close && !fault_flag, "R5 pass runs", {run_cmd, fault_flag}, 2);
            stop_req = 1; nclk(1); stop_req = 0;
            chk(!run_cmd && slave_rst_n && main_close, "R8 step1",
                {run_cmd, slave_rst_n, main_close}, 3);
            nclk(1);
            chk(!slave_rst_n && main_close, "R8 step2", {slave_rst_n, main_close}, 1);
            nclk(1);
            chk(!main_close && !fault_flag && !slave_rst_n, "R8 step3 idle",
                {main_close, fault_flag, slave_rst_n}, 0);
         end else begin
            nclk(2);
            chk(fault_flag && fault_code == 2 && !main_close, "R5 bus low fault",
                fault_code, 2);
            clear_fault();
            chk(!fault_flag && fault_code == 0, "R10 clear", {fault_flag, fault_code}, 0);
         end
      end

      // R3: unhealthy drive
      healthy = 0; chg_seen = 0;
      pulse_start(); nclk(1); pass_params(); nclk(4);
      chk(fault_flag && fault_code == 1, "R3 unhealthy fault", fault_code, 1);
      chk(!chg_seen, "R3 no precharge", chg_seen, 0);

      // R10: start ignored while faulted
      pulse_start(); nclk(2);
      chk(fault_flag && !slave_rst_n && fault_code == 1, "R10 fault holds",
          {fault_flag, slave_rst_n}, 2);
      clear_fault();
      chk(!fault_flag && fault_code == 0 && !slave_rst_n, "R10 back to idle",
          {fault_flag, fault_code}, 0);

      // R11 and R9: reach run, try start, then trip with stop
      healthy = 1; bus_sample = 12'd1000; bus_rated = 12'd1000;
      pulse_start(); nclk(1); pass_params();
      run_window(cnt); nclk(2);
      chk(run_cmd == 1, "R9 reached run", run_cmd, 1);
      pulse_start(); nclk(1);
      chk(run_cmd && main_close, "R11 start ignored in run", {run_cmd, main_close}, 3);
      trip = 1; stop_req = 1; nclk(1); trip = 0; stop_req = 0;
      chk(!run_cmd && slave_rst_n && main_close, "R9 step1",
          {run_cmd, slave_rst_n, main_close}, 3);
      nclk(1);
      chk(!slave_rst_n && main_close, "R9 step2", {slave_rst_n, main_close}, 1);
      nclk(1);
      chk(!main_close && fault_flag && fault_code == 3, "R9 trip fault", fault_code, 3);
      clear_fault();

      // R9: trip during parameter exchange
      main_seen = 0;
      pulse_start(); nclk(1);
      trip = 1; nclk(1); trip = 0; nclk(2);
      chk(fault_flag && fault_code == 3 && !main_seen, "R9 trip in param", fault_code, 3);
      clear_fault();

      // R7: never both contactors
      chk(!overlap_seen, "R7 no overlap", overlap_seen, 0);
      summary();
   end
endmodule